// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines into a single interrupt output for one processor input. Each request line passes through a two-flop synchronizer into a raw status register. A per-source mask register decides which raised sources count as pending. The OR of all pending bits is registered and drives the combined interrupt output.

Software reaches the block through a simple synchronous register bus with an address, a write strobe with data, and a read strobe with registered read data. The mask cannot be written directly. It changes only through two write-only ports. One masks every source whose data bit is 1, and the other unmasks every source whose data bit is 1, so no read-modify-write sequence is needed. A handler reads the pending view and services whichever sources are both raised and unmasked. A source stays pending while its line is held high, because the block has no acknowledge register.

Top module: `irq_ctrl_top`

## Requirements
- R1: While reset is low and right after it, every mask bit is 1, `irq_o` is 0 and `bus_rd_data` is 0. A read of the mask at byte offset 0x04 after reset returns 0xFFFFFFFF.
- R2: Bit i of the status register (offset 0x00) follows request line i with a latency of two clock edges. It falls when the line falls, with no latching.
- R3: A write to offset 0x08 sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: A write to offset 0x0C clears every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R5: A read of offset 0x04 returns the current mask, with 1 meaning masked and bit i belonging to source i.
- R6: A read of offset 0x10 returns the pending vector, which is status AND NOT mask.
- R7: `irq_o` is the OR of all pending bits, delayed by one register. A request raised on an unmasked line therefore shows on `irq_o` three clock edges after the line rises.
- R8: Writes to offsets 0x00, 0x04, 0x10 and to any unmapped offset leave the mask unchanged. Reads of offsets 0x08, 0x0C and of any unmapped offset return 0.
- R9: Read data appears on `bus_rd_data` at the clock edge that samples `bus_rd_en`. It returns to 0 on any edge where `bus_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 32 | Level-sensitive request lines, one per source |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt toward the processor |

## Verification
The hardest cases to reach from the ports are the exact latency of the request path and the fact that a source's level is never latched. Both need the request, the mask and the output observed edge by edge rather than after things settle. The stimulus unmasks a single source and raises its line on a known falling edge. It then samples `irq_o` after each of the next three rising edges, and repeats the sequence when the line drops. A table of mixed request and mask patterns covers the rest, including a pattern where every line is high and everything is masked. Stray writes to read-only and unmapped offsets are followed by mask readbacks.

// File: rtl/irqc_pkg.sv
// Package: shared sizes and register offsets for the interrupt controller.
// Assumes byte addressing with 32-bit registers on word-aligned offsets.
package irqc_pkg;
    localparam int IRQ_NUM  = 32;
    localparam int BUS_AW   = 8;
    localparam int BUS_DW   = 32;
    localparam int SYNC_LEN = 2;

    localparam logic [BUS_AW-1:0] OFS_RAW  = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_MSK  = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_MSET = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_MCLR = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_PEND = 8'h10;
endpackage

// File: rtl/irqc_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous levels.
// Assumes each bit is an independent level, so no bus coherency is needed.
module irqc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw lines in the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                // Move the value one stage further along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_mask_reg.sv
// Module: per-source mask held in flops and changed by set and clear vectors.
// Assumes set and clear come from separate write ports. Set wins on a tie.
module irqc_mask_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] mask_o
);
    logic [WIDTH-1:0] mask_q;

    // Reset masks everything. Otherwise clear first, then apply set on top.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= (mask_q & ~clr_i) | set_i;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/irqc_combine.sv
// Module: builds the pending vector and the registered combined interrupt.
// Assumes status is already synchronous to clk.
module irqc_combine #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] status_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic [WIDTH-1:0] pend_o,
    output logic             irq_o
);
    logic irq_q;

    // A source is pending when it is raised and not masked.
    always_comb begin
        pend_o = status_i & ~mask_i;
    end

    // Register the OR of all pending sources toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pend_o;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/irqc_regif.sv
// Module: decodes the register bus into mask strobes and a registered read mux.
// Assumes single-cycle strobes and full-address decode with no aliasing.
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int WIDTH = IRQ_NUM,
    parameter int AW    = BUS_AW,
    parameter int DW    = BUS_DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             wr_en_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic             rd_en_i,
    output logic [DW-1:0]    rd_data_o,
    input  logic [WIDTH-1:0] status_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic [WIDTH-1:0] pend_i,
    output logic [WIDTH-1:0] set_o,
    output logic [WIDTH-1:0] clr_o
);
    logic [DW-1:0] status_ext;
    logic [DW-1:0] mask_ext;
    logic [DW-1:0] pend_ext;
    logic [DW-1:0] rd_sel;
    logic [DW-1:0] rd_q;

    // Widen the source vectors to the bus width with zero fill.
    always_comb begin
        status_ext = '0;
        mask_ext   = '0;
        pend_ext   = '0;
        status_ext[WIDTH-1:0] = status_i;
        mask_ext[WIDTH-1:0]   = mask_i;
        pend_ext[WIDTH-1:0]   = pend_i;
    end

    // Turn writes to the two mask ports into per-bit strobes.
    always_comb begin
        set_o = '0;
        clr_o = '0;
        if (wr_en_i && addr_i == OFS_MSET) set_o = wr_data_i[WIDTH-1:0];
        if (wr_en_i && addr_i == OFS_MCLR) clr_o = wr_data_i[WIDTH-1:0];
    end

    // Select the readable register. Everything else reads as zero.
    always_comb begin
        unique case (addr_i)
            OFS_RAW:  rd_sel = status_ext;
            OFS_MSK:  rd_sel = mask_ext;
            OFS_PEND: rd_sel = pend_ext;
            default:  rd_sel = '0;
        endcase
    end

    // Register the read data and drive zero when no read is active.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_sel;
        else              rd_q <= '0;
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/irq_ctrl_top.sv
// Module: top of the level-sensitive interrupt controller.
// Assumes request lines are asynchronous levels that stay high until serviced.
module irq_ctrl_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = IRQ_NUM,
    parameter int AW      = BUS_AW,
    parameter int DW      = BUS_DW,
    parameter int SYNC_N  = SYNC_LEN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_wr_en,
    input  logic [DW-1:0]      bus_wr_data,
    input  logic               bus_rd_en,
    output logic [DW-1:0]      bus_rd_data,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] set_w;
    logic [NUM_SRC-1:0] clr_w;

    irqc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_i),
        .q_o   (status_q)
    );

    irqc_mask_reg #(.WIDTH(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_w),
        .clr_i  (clr_w),
        .mask_o (mask_q)
    );

    irqc_combine #(.WIDTH(NUM_SRC)) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_q),
        .mask_i   (mask_q),
        .pend_o   (pend_w),
        .irq_o    (irq_o)
    );

    irqc_regif #(.WIDTH(NUM_SRC), .AW(AW), .DW(DW)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr),
        .wr_en_i   (bus_wr_en),
        .wr_data_i (bus_wr_data),
        .rd_en_i   (bus_rd_en),
        .rd_data_o (bus_rd_data),
        .status_i  (status_q),
        .mask_i    (mask_q),
        .pend_i    (pend_w),
        .set_o     (set_w),
        .clr_o     (clr_w)
    );
endmodule

// File: rtl/irq_ctrl_chk.sv
// Module: assertion checker bound to irq_ctrl_top.
// Assumes the default source count and bus widths from the package.
module irq_ctrl_chk
    import irqc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [IRQ_NUM-1:0] req_i,
    input logic [IRQ_NUM-1:0] status,
    input logic [IRQ_NUM-1:0] mask,
    input logic [IRQ_NUM-1:0] set_vec,
    input logic [IRQ_NUM-1:0] clr_vec,
    input logic [BUS_AW-1:0]  addr,
    input logic               rd_en,
    input logic [BUS_DW-1:0]  rd_data,
    input logic               irq_o
);
    logic [1:0] live_cnt;
    logic       unmapped;

    // Count clock edges since reset was released, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)             live_cnt <= '0;
        else if (live_cnt != 3) live_cnt <= live_cnt + 2'd1;
    end

    // Flag offsets that hold no readable register.
    always_comb begin
        unmapped = (addr != OFS_RAW) && (addr != OFS_MSK) && (addr != OFS_PEND);
    end

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == 3) |-> (status == $past(req_i, 2))); // R2
    AST_SET_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((mask & $past(set_vec)) == $past(set_vec))); // R3
    AST_CLR_UNMASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((mask & $past(clr_vec) & ~$past(set_vec)) == '0)); // R4
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0 && clr_vec == '0) |=> $stable(mask)); // R8
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt != 0) |-> (irq_o == $past(|(status & ~mask)))); // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && unmapped) |=> (rd_data == '0)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> (rd_data == '0)); // R9
endmodule

bind irq_ctrl_top irq_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .status  (status_q),
    .mask    (mask_q),
    .set_vec (set_w),
    .clr_vec (clr_w),
    .addr    (bus_addr),
    .rd_en   (bus_rd_en),
    .rd_data (bus_rd_data),
    .irq_o   (irq_o)
);

// File: tb/irq_ctrl_top_tb.sv
// Bench: vector table walk plus directed tests for the interrupt controller.
module irq_ctrl_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_i = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rd_data;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // 50 MHz clock
    always #10 clk = ~clk;

    irq_ctrl_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .bus_rd_en   (bus_rd_en),
        .bus_rd_data (bus_rd_data),
        .irq_o       (irq_o)
    );

    // Each row: request, clear-mask data, set-mask data, expected pending, expected irq
    typedef struct packed {
        logic [31:0] req;
        logic [31:0] clr;
        logic [31:0] set;
        logic [31:0] pend;
        logic        irq;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 1'b1},
        '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0000, 1'b1},
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0},
        '{32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0000_0000, 32'hF000_F000, 1'b1},
        '{32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h0000_0000, 1'b0},
        '{32'h1234_5678, 32'h0F0F_0F0F, 32'h0000_0F00, 32'h0204_0008, 1'b1},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called on a falling edge; returns on the next falling edge.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wr_data = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        d = bus_rd_data;
        bus_rd_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] mask_before;

        // R1: state during reset
        repeat (3) @(negedge clk);
        check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
        check("R1 rd_data in reset", bus_rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        bus_read(8'h04, rd);
        check("R1 R5 mask after reset", rd, 32'hFFFF_FFFF);
        // R9: data returns to zero when no read is active
        @(negedge clk);
        check("R9 idle rd_data", bus_rd_data, 32'h0);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            req_i = VECS[i].req;
            bus_write(8'h08, 32'hFFFF_FFFF);
            bus_write(8'h0C, VECS[i].clr);
            bus_write(8'h08, VECS[i].set);
            @(negedge clk);
            check($sformatf("R7 irq vec %0d", i), {31'b0, irq_o}, {31'b0, VECS[i].irq});
            bus_read(8'h10, rd);
            check($sformatf("R6 pending vec %0d", i), rd, VECS[i].pend);
            bus_read(8'h00, rd);
            check($sformatf("R2 status vec %0d", i), rd, VECS[i].req);
            bus_read(8'h04, rd);
            check($sformatf("R5 mask vec %0d", i), rd, ~VECS[i].clr | VECS[i].set);
        end

        // R2 R7: edge-by-edge latency on one source
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h0C, 32'h0000_0008);
        @(negedge clk);
        req_i = 32'h0000_0008;
        @(negedge clk);
        check("R7 irq after edge 1", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R7 irq after edge 2", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R7 irq after edge 3", {31'b0, irq_o}, 32'h1);
        req_i = 32'h0;
        @(negedge clk);
        @(negedge clk);
        check("R2 irq held two edges after drop", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        check("R2 irq falls with line", {31'b0, irq_o}, 32'h0);
        bus_read(8'h00, rd);
        check("R2 status no latching", rd, 32'h0);

        // R3 R4: zero bits leave the mask alone
        bus_read(8'h04, mask_before);
        bus_write(8'h08, 32'h0);
        bus_read(8'h04, rd);
        check("R3 zero set keeps mask", rd, mask_before);
        bus_write(8'h0C, 32'h0);
        bus_read(8'h04, rd);
        check("R4 zero clear keeps mask", rd, mask_before);
        bus_write(8'h08, 32'h0000_0100);
        bus_read(8'h04, rd);
        check("R3 single set", rd, mask_before | 32'h0000_0100);
        bus_write(8'h0C, 32'h8000_0001);
        bus_read(8'h04, rd);
        check("R4 partial clear", rd, (mask_before | 32'h0000_0100) & ~32'h8000_0001);

        // R8: writes elsewhere do not touch the mask
        bus_read(8'h04, mask_before);
        bus_write(8'h04, 32'h0000_0000);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_write(8'h09, 32'hFFFF_FFFF);
        bus_write(8'h0D, 32'hFFFF_FFFF);
        bus_read(8'h04, rd);
        check("R8 stray writes keep mask", rd, mask_before);

        // R8: write-only and unmapped offsets read zero
        req_i = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        bus_read(8'h08, rd);
        check("R8 set port reads zero", rd, 32'h0);
        bus_read(8'h0C, rd);
        check("R8 clear port reads zero", rd, 32'h0);
        bus_read(8'h14, rd);
        check("R8 unmapped 0x14 reads zero", rd, 32'h0);
        bus_read(8'h01, rd);
        check("R8 unaligned 0x01 reads zero", rd, 32'h0);
        bus_read(8'h00, rd);
        check("R2 all lines high", rd, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R9 rd_data clears", bus_rd_data, 32'h0);

        // R1: reset again restores the masked state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 irq in second reset", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        bus_read(8'h04, rd);
        check("R1 mask after second reset", rd, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        check("R1 all masked keeps irq low", {31'b0, irq_o}, 32'h0);

        finish_run();
    end
endmodule